// File: doc/BRIEF.md
# Keyed Dual Signed Multiply-Add

This block gathers four 8-bit two's-complement operands from one shared data bus and forms the signed sum of two products, `a0*b0 + a1*b1`. Each operand register has its own load key. When that key rises, the value on the shared bus is written into that register. A separate compute key, on its rising edge, evaluates the multiply-add and writes it into a 16-bit result register. The result register then holds that value until the next compute event.

All four held operands drive the outputs at all times next to the result, so a display stage downstream can show every operand and the result. The keys arrive already debounced. Each key is edge detected against its value in the previous cycle, so a key that stays high produces exactly one event. Reset is synchronous and active high.

Top module: `dual_mac_keyed`

## Requirements
- R1: While `rst` is high at a clock edge, all four operand registers, the result register and the key history are cleared to zero. All operand outputs and `sumOut` then read 0.
- R2: `sumOut` is the 16-bit value of `opA0*opB0 + opA1*opB1`. Every operand is read as an 8-bit two's-complement number, in the range -128 to 127.
- R3: A rising edge of a load key (low in the previous cycle, high in this cycle) writes `dataIn` into that key's operand register at that clock edge. The new value shows on the operand output one cycle after the key was first seen high.
- R4: An operand register whose key has no rising edge keeps its value. Changes on `dataIn` do not reach it.
- R5: A key held high for several cycles produces only one event. Releasing the key and pressing it again produces a new event.
- R6: `sumOut` changes only on a compute rising edge, and it is updated at that clock edge. Reloading an operand after a compute leaves `sumOut` unchanged until the next compute.
- R7: Each product is formed at full 16-bit signed width, and the sum wraps modulo 2^16. With all four operands at -128 (0x80), `sumOut` reads 0x8000.
- R8: Several keys may rise in the same cycle. Every load key among them captures the same `dataIn`. A compute in that same cycle uses the operand values held before the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 8 | Shared operand bus, two's complement |
| loadKeyA0 | input | 1 | Load key for operand a0 |
| loadKeyB0 | input | 1 | Load key for operand b0 |
| loadKeyA1 | input | 1 | Load key for operand a1 |
| loadKeyB1 | input | 1 | Load key for operand b1 |
| computeKey | input | 1 | Compute key, evaluates the multiply-add |
| opA0 | output | 8 | Held operand a0 |
| opB0 | output | 8 | Held operand b0 |
| opA1 | output | 8 | Held operand a1 |
| opB1 | output | 8 | Held operand b1 |
| sumOut | output | 16 | Registered a0*b0 + a1*b1 |

## Verification
Between a key and the output it affects there is exactly one register. A key raised before clock edge N therefore shows its operand or result after edge N. The bench changes its inputs on falling edges and reads outputs on the falling edge after the capturing rising edge, so every value is read one cycle after its key. The held-key and release checks read several later falling edges, which shows that no second event happens. Result-hold checks read `sumOut` after an operand reload and before any new compute.

// File: rtl/dual_mac_pkg.sv
package dual_mac_pkg;
  parameter int OP_W   = 8;
  parameter int OP_CNT = 4;

  // Operand slot order within the load vector
  localparam int SLOT_A0 = 0;
  localparam int SLOT_B0 = 1;
  localparam int SLOT_A1 = 2;
  localparam int SLOT_B1 = 3;

  typedef struct packed {
    logic [OP_CNT-1:0] load;
    logic              compute;
  } keyStrobe_t;
endpackage

// File: rtl/dual_mac_key_ctrl.sv
module dual_mac_key_ctrl
  import dual_mac_pkg::*;
#(
  parameter int KEY_N = OP_CNT + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_N-1:0] keyIn,
  output keyStrobe_t       strobe
);
  logic [KEY_N-1:0] keyPrev;
  logic [KEY_N-1:0] keyRise;

  always_ff @(posedge clk) begin
    if (rst) keyPrev <= '0;
    else     keyPrev <= keyIn;
  end

  genvar k;
  generate
    for (k = 0; k < KEY_N; k++) begin : g_edge
      assign keyRise[k] = keyIn[k] & ~keyPrev[k];
      AST_ONE_EVENT_PER_PRESS: assert property (@(posedge clk) disable iff (rst)
        keyRise[k] |=> !keyRise[k]); // R5
    end
  endgenerate

  assign strobe.load    = keyRise[OP_CNT-1:0];
  assign strobe.compute = keyRise[KEY_N-1];
endmodule

// File: rtl/dual_mac_datapath.sv
module dual_mac_datapath
  import dual_mac_pkg::*;
#(
  parameter int DATA_W = OP_W,
  parameter int RES_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  keyStrobe_t        strobe,
  output logic [DATA_W-1:0] opVal [OP_CNT],
  output logic [RES_W-1:0]  result
);
  logic signed [RES_W-1:0] prodLo;
  logic signed [RES_W-1:0] prodHi;
  logic        [RES_W-1:0] sumNext;

  genvar i;
  generate
    for (i = 0; i < OP_CNT; i++) begin : g_op
      always_ff @(posedge clk) begin
        if (rst)                opVal[i] <= '0;
        else if (strobe.load[i]) opVal[i] <= dataIn;
      end
      AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        strobe.load[i] |=> opVal[i] == $past(dataIn)); // R3
      AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe.load[i] |=> $stable(opVal[i])); // R4
    end
  endgenerate

  // Signed products at full width; the sum wraps modulo 2^RES_W
  assign prodLo  = $signed(opVal[SLOT_A0]) * $signed(opVal[SLOT_B0]);
  assign prodHi  = $signed(opVal[SLOT_A1]) * $signed(opVal[SLOT_B1]);
  assign sumNext = prodLo + prodHi;

  always_ff @(posedge clk) begin
    if (rst)                 result <= '0;
    else if (strobe.compute) result <= sumNext;
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.compute |=> $stable(result)); // R6
  AST_RESULT_FROM_PRIOR_OPS: assert property (@(posedge clk) disable iff (rst)
    strobe.compute |=> result == $past(sumNext)); // R8
endmodule

// File: rtl/dual_mac_keyed.sv
module dual_mac_keyed
  import dual_mac_pkg::*;
#(
  parameter int DATA_W = OP_W,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              loadKeyA0,
  input  logic              loadKeyB0,
  input  logic              loadKeyA1,
  input  logic              loadKeyB1,
  input  logic              computeKey,
  output logic [DATA_W-1:0] opA0,
  output logic [DATA_W-1:0] opB0,
  output logic [DATA_W-1:0] opA1,
  output logic [DATA_W-1:0] opB1,
  output logic [RES_W-1:0]  sumOut
);
  keyStrobe_t        strobe;
  logic [OP_CNT:0]   keyVec;
  logic [DATA_W-1:0] opVal [OP_CNT];

  assign keyVec = {computeKey, loadKeyB1, loadKeyA1, loadKeyB0, loadKeyA0};

  dual_mac_key_ctrl #(.KEY_N(OP_CNT + 1)) ctrl_i (
    .clk(clk), .rst(rst), .keyIn(keyVec), .strobe(strobe)
  );

  dual_mac_datapath #(.DATA_W(DATA_W), .RES_W(RES_W)) dp_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .strobe(strobe),
    .opVal(opVal), .result(sumOut)
  );

  assign opA0 = opVal[SLOT_A0];
  assign opB0 = opVal[SLOT_B0];
  assign opA1 = opVal[SLOT_A1];
  assign opB1 = opVal[SLOT_B1];
endmodule

// File: tb/dual_mac_keyed_tb.sv
module dual_mac_keyed_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] dataIn = '0;
  logic ka0 = 0, kb0 = 0, ka1 = 0, kb1 = 0, kc = 0;
  logic [7:0] opA0, opB0, opA1, opB1;
  logic [15:0] sumOut;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  dual_mac_keyed dut_i (
    .clk(clk), .rst(rst), .dataIn(dataIn),
    .loadKeyA0(ka0), .loadKeyB0(kb0), .loadKeyA1(ka1), .loadKeyB1(kb1),
    .computeKey(kc),
    .opA0(opA0), .opB0(opB0), .opA1(opA1), .opB1(opB1), .sumOut(sumOut)
  );

  function automatic logic [15:0] model(input logic [7:0] a0, b0, a1, b1);
    int s;
    s = int'($signed(a0)) * int'($signed(b0)) + int'($signed(a1)) * int'($signed(b1));
    return 16'(s);
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setKey(input int idx, input logic v);
    case (idx)
      0: ka0 = v; 1: kb0 = v; 2: ka1 = v; 3: kb1 = v; default: kc = v;
    endcase
  endtask

  // one press: drive at a falling edge, capture on the next rising edge, release and settle
  task automatic press(input int idx, input logic [7:0] v);
    @(negedge clk); dataIn = v; setKey(idx, 1'b1);
    @(negedge clk); setKey(idx, 1'b0);
  endtask

  task automatic loadAll(input logic [7:0] a0, b0, a1, b1);
    press(0, a0); press(1, b0); press(2, a1); press(3, b1);
  endtask

  task automatic tReset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R1", "opA0 after reset", {8'h0, opA0}, 16'h0);
    chk("R1", "opB1 after reset", {8'h0, opB1}, 16'h0);
    chk("R1", "sumOut after reset", sumOut, 16'h0);
  endtask

  task automatic tBasic;
    loadAll(8'd3, 8'd4, 8'd5, 8'd6);
    chk("R3", "opA0 loaded", {8'h0, opA0}, 16'd3);
    chk("R3", "opB1 loaded", {8'h0, opB1}, 16'd6);
    chk("R6", "sumOut before compute", sumOut, 16'h0);
    press(4, 8'h00);
    chk("R2", "3*4+5*6", sumOut, 16'd42);
  endtask

  task automatic tSigns;
    loadAll(8'hF6, 8'd7, 8'h81, 8'h80); // -10*7 + -127*-128
    press(4, 8'h00);
    chk("R2", "mixed signs", sumOut, model(8'hF6, 8'd7, 8'h81, 8'h80));
    loadAll(8'd127, 8'hFF, 8'h00, 8'h55); // -127 + 0
    press(4, 8'h00);
    chk("R2", "127*-1+0", sumOut, 16'hFF81);
  endtask

  task automatic tHoldResult;
    logic [15:0] prev;
    prev = sumOut;
    press(0, 8'd9);
    chk("R6", "sumOut after reload", sumOut, prev);
    chk("R4", "opB0 kept", {8'h0, opB0}, 16'h00FF);
    @(negedge clk); dataIn = 8'h3C;
    @(negedge clk);
    chk("R4", "opA0 ignores bus", {8'h0, opA0}, 16'd9);
    press(4, 8'h00);
    chk("R6", "sumOut after new compute", sumOut, model(8'd9, 8'hFF, 8'h00, 8'h55));
  endtask

  task automatic tHeld;
    @(negedge clk); dataIn = 8'd21; ka1 = 1'b1;
    @(negedge clk); dataIn = 8'd22;
    @(negedge clk); dataIn = 8'd23;
    @(negedge clk);
    chk("R5", "held key one capture", {8'h0, opA1}, 16'd21);
    ka1 = 1'b0;
    @(negedge clk);
    press(2, 8'd24);
    chk("R5", "re-press captures", {8'h0, opA1}, 16'd24);
    // held compute: change an operand mid-hold, result must not follow
    @(negedge clk); kc = 1'b1;
    @(negedge clk);
    chk("R5", "compute held first", sumOut, model(8'd9, 8'hFF, 8'd24, 8'h55));
    dataIn = 8'd1; kb1 = 1'b1;
    @(negedge clk); kb1 = 1'b0;
    @(negedge clk);
    chk("R5", "compute held no second", sumOut, model(8'd9, 8'hFF, 8'd24, 8'h55));
    kc = 1'b0;
  endtask

  task automatic tOverflow;
    loadAll(8'h80, 8'h80, 8'h80, 8'h80);
    press(4, 8'h00);
    chk("R7", "(-128)^2 twice wraps", sumOut, 16'h8000);
  endtask

  task automatic tSimul;
    logic [15:0] prev;
    loadAll(8'd2, 8'd3, 8'd4, 8'd5);
    press(4, 8'h00);
    prev = sumOut;
    chk("R2", "2*3+4*5", prev, 16'd26);
    @(negedge clk); dataIn = 8'hFD; ka0 = 1; kb0 = 1; ka1 = 1; kb1 = 1; kc = 1;
    @(negedge clk); ka0 = 0; kb0 = 0; ka1 = 0; kb1 = 0; kc = 0;
    chk("R8", "all loads same value a0", {8'h0, opA0}, 16'h00FD);
    chk("R8", "all loads same value b1", {8'h0, opB1}, 16'h00FD);
    chk("R8", "compute used prior operands", sumOut, prev);
    press(4, 8'h00);
    chk("R8", "next compute uses new", sumOut, 16'd18);
  endtask

  initial begin
    tReset();
    tBasic();
    tSigns();
    tHoldResult();
    tHeld();
    tOverflow();
    tSimul();
    tReset();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule